// File: doc/BRIEF.md
# Relocatable Boot-Memory Window Decoder

This block places a Flash/ROM device at a programmable window in a 32-bit address space. It holds one 32-bit control word, which is reached through a simple register port at a single fixed address. A combinational decoder compares every bus address against that window. The window's base is a 12-bit field that covers address bits [31:20]. A 3-bit size code selects a window from 1 MB to 128 MB. As the window grows, the low base bits take no part in the compare, so a window always starts at a whole multiple of its own size.

Two strap inputs are captured while reset is active. One gives the read-only bus-width flag. The other enables a boot mirror, which answers the top megabyte of the address space (0xFFF00000 to 0xFFFFFFFF) with the block's first megabyte. This lets a processor fetch its reset vector before software relocates the device. The decoder produces a block-select. For write cycles it also produces either a write-permit or a write-reject, based on the software write-enable bit.

Top module: `rom_window_dec`

## Requirements
- R1: While `rst` is high at a clock edge, the control word loads base 0xFF4, size code 0, enable 0 and write-enable 0. It also captures `strap_bus_w` into the bus-width bit and `strap_alias` into the mirror bit.
- R2: The control word has this layout, with bit 31 as the MSB. Bits [31:20] hold the base. Bit 19 is bus width. Bits [18:16] are the size code, with bit 18 as its MSB. Bits [15:3] always read 0. Bit 2 is the mirror bit, bit 1 is enable and bit 0 is write-enable.
- R3: A cycle with `reg_wr` high and `reg_addr` equal to 0xFEF80058 loads the base, the size code, enable and write-enable from `reg_wdata` at the next edge.
- R4: Register writes leave the bus-width bit, the mirror bit and bits [15:3] unchanged. Strap changes after reset also leave them unchanged.
- R5: `reg_rdata` shows the control word when `reg_addr` equals 0xFEF80058, and shows 0 for any other address. A write to any other address changes nothing.
- R6: With enable set and size code n, `blk_sel` is high for every address A in [S, S + 2^(20+n)). Here S is {base, 20'b0} with the low 20+n bits cleared. It is low for S-1 and for S + 2^(20+n) unless the mirror applies.
- R7: With enable clear, `blk_sel`, `wr_permit` and `wr_reject` are all low for every address.
- R8: With enable and the mirror bit both set, every address from 0xFFF00000 to 0xFFFFFFFF selects the block. With the mirror bit clear, that range selects only through the base compare.
- R9: `wr_permit` is high exactly when `blk_sel`, `bus_wr` and the write-enable bit are all high.
- R10: `wr_reject` is high exactly when `blk_sel` and `bus_wr` are high and the write-enable bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_bus_w | input | 1 | Bus-width strap, captured during reset |
| strap_alias | input | 1 | Boot-mirror strap, captured during reset |
| reg_addr | input | 32 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_addr | input | 32 | Bus address to decode |
| bus_wr | input | 1 | Bus cycle is a write |
| blk_sel | output | 1 | Address falls in the window or the mirror |
| wr_permit | output | 1 | Selected write with write-enable set |
| wr_reject | output | 1 | Selected write with write-enable clear |

## Verification
The decoder is tested at four addresses for each of the eight size codes: the window start, its last byte, one byte past the end and one byte before the start. The base used has ones in its low bits, so a decoder that forgets to mask them misses the start of larger windows, and a decoder that masks too many bits hits past the end. Addresses in the mirror range are applied twice, once with the mirror strap captured high and once low. Each of these addresses uses a base that lies outside the mirror, so that any hit can come only from the mirror. Read and write cycles are mixed while write-enable is set and while it is clear, which separates permit from reject. Register writes with every bit set and every bit clear, and writes to a neighbouring address, show whether read-only bits and the decode of the register address are kept.

// File: rtl/rom_win_pkg.sv
package rom_win_pkg;

    parameter int ADDR_W   = 32;
    parameter int BASE_W   = 12;
    parameter int SIZE_W   = 3;
    parameter int BLK_LSB  = ADDR_W - BASE_W;          // 1 MB granule
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hFEF8_0058;
    parameter logic [BASE_W-1:0] BASE_RST  = 12'hFF4;
    parameter logic [BASE_W-1:0] MIRROR_TAG = '1;     // top granule

    // Field positions inside the control word
    parameter int F_BASE_LSB = BLK_LSB;
    parameter int F_BUSW     = BLK_LSB - 1;
    parameter int F_SIZE_LSB = F_BUSW - SIZE_W;
    parameter int F_MIRROR   = 2;
    parameter int F_EN       = 1;
    parameter int F_WE       = 0;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              bus_w;
        logic [SIZE_W-1:0] size;
        logic              mirror;
        logic              en;
        logic              we;
    } ctrl_t;

    typedef struct packed {
        logic sel;
        logic permit;
        logic reject;
    } dec_t;

    // Keep-mask: base bit j takes part in the compare only when j >= size
    function automatic logic [BASE_W-1:0] keep_mask(input logic [SIZE_W-1:0] sz);
        logic [BASE_W-1:0] m;
        for (int j = 0; j < BASE_W; j++) begin
            m[j] = (j >= int'(sz));
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] pack_ctrl(input ctrl_t c);
        logic [ADDR_W-1:0] w;
        w = '0;
        w[F_BASE_LSB +: BASE_W] = c.base;
        w[F_BUSW]               = c.bus_w;
        w[F_SIZE_LSB +: SIZE_W] = c.size;
        w[F_MIRROR]             = c.mirror;
        w[F_EN]                 = c.en;
        w[F_WE]                 = c.we;
        return w;
    endfunction

endpackage

// File: rtl/rom_win_regs.sv
module rom_win_regs
    import rom_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_bus_w,
    input  logic              strap_alias,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output ctrl_t             ctrl
);

    logic hit_reg;
    assign hit_reg = (reg_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.base   <= BASE_RST;
            ctrl.size   <= '0;
            ctrl.en     <= 1'b0;
            ctrl.we     <= 1'b0;
            ctrl.bus_w  <= strap_bus_w;
            ctrl.mirror <= strap_alias;
        end else if (reg_wr && hit_reg) begin
            ctrl.base <= reg_wdata[F_BASE_LSB +: BASE_W];
            ctrl.size <= reg_wdata[F_SIZE_LSB +: SIZE_W];
            ctrl.en   <= reg_wdata[F_EN];
            ctrl.we   <= reg_wdata[F_WE];
        end
    end

    assign reg_rdata = hit_reg ? pack_ctrl(ctrl) : '0;

endmodule

// File: rtl/rom_win_match.sv
module rom_win_match
    import rom_win_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] addr,
    output logic              base_hit,
    output logic              mirror_hit
);

    logic [BASE_W-1:0] keep;
    logic [BASE_W-1:0] bit_ok;

    assign keep = keep_mask(ctrl.size);

    for (genvar j = 0; j < BASE_W; j++) begin : g_cmp
        assign bit_ok[j] = !keep[j] || (addr[BLK_LSB + j] == ctrl.base[j]);
    end

    assign base_hit   = &bit_ok;
    assign mirror_hit = ctrl.mirror && (addr[ADDR_W-1:BLK_LSB] == MIRROR_TAG);

endmodule

// File: rtl/rom_win_permit.sv
module rom_win_permit
    import rom_win_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  base_hit,
    input  logic  mirror_hit,
    input  logic  bus_wr,
    output dec_t  dec
);

    always_comb begin
        dec.sel    = ctrl.en && (base_hit || mirror_hit);
        dec.permit = dec.sel && bus_wr && ctrl.we;
        dec.reject = dec.sel && bus_wr && !ctrl.we;
    end

endmodule

// File: rtl/rom_window_dec.sv
module rom_window_dec
    import rom_win_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_bus_w,
    input  logic        strap_alias,
    input  logic [31:0] reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] bus_addr,
    input  logic        bus_wr,
    output logic        blk_sel,
    output logic        wr_permit,
    output logic        wr_reject
);

    ctrl_t ctrl;
    dec_t  dec;
    logic  base_hit;
    logic  mirror_hit;

    rom_win_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .strap_bus_w (strap_bus_w),
        .strap_alias (strap_alias),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ctrl        (ctrl)
    );

    rom_win_match u_match (
        .ctrl       (ctrl),
        .addr       (bus_addr),
        .base_hit   (base_hit),
        .mirror_hit (mirror_hit)
    );

    rom_win_permit u_permit (
        .ctrl       (ctrl),
        .base_hit   (base_hit),
        .mirror_hit (mirror_hit),
        .bus_wr     (bus_wr),
        .dec        (dec)
    );

    assign blk_sel   = dec.sel;
    assign wr_permit = dec.permit;
    assign wr_reject = dec.reject;

endmodule

// File: rtl/rom_window_dec_chk.sv
module rom_window_dec_chk
    import rom_win_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input ctrl_t       ctrl,
    input logic [31:0] reg_rdata,
    input logic [31:0] bus_addr,
    input logic        bus_wr,
    input logic        blk_sel,
    input logic        wr_permit,
    input logic        wr_reject
);

    AST_RESET_LOADS: assert property (@(posedge clk)
        rst |=> (ctrl.base == BASE_RST) && !ctrl.en && !ctrl.we && (ctrl.size == '0)); // R1

    AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[F_SIZE_LSB-1:F_MIRROR+1] == '0); // R2

    AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(!rst)) |-> ($stable(ctrl.bus_w) && $stable(ctrl.mirror))); // R4

    AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        blk_sel |-> ctrl.en); // R7

    AST_MIRROR_SELECTS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.mirror && (bus_addr[31:20] == 12'hFFF)) |-> blk_sel); // R8

    AST_PERMIT_GATED: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> (blk_sel && bus_wr && ctrl.we)); // R9

    AST_REJECT_GATED: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> (blk_sel && bus_wr && !ctrl.we && !wr_permit)); // R10

endmodule

bind rom_window_dec rom_window_dec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .reg_rdata (reg_rdata),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .blk_sel   (blk_sel),
    .wr_permit (wr_permit),
    .wr_reject (wr_reject)
);

// File: tb/rom_window_dec_bench.sv
module rom_window_dec_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] REG_A = 32'hFEF8_0058;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_bus_w = 1'b1;
    logic        strap_alias = 1'b1;
    logic [31:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        blk_sel, wr_permit, wr_reject;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_window_dec u_rom_window_dec (
        .clk(clk), .rst(rst), .strap_bus_w(strap_bus_w), .strap_alias(strap_alias),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_addr(bus_addr), .bus_wr(bus_wr),
        .blk_sel(blk_sel), .wr_permit(wr_permit), .wr_reject(wr_reject)
    );

    typedef struct {
        bit          is_read;
        logic [31:0] exp_data;
        logic        exp_sel, exp_ok, exp_rej;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Model state, built from the requirements
    logic [11:0] m_base;
    logic [2:0]  m_size;
    logic        m_bw, m_mir, m_en, m_we;

    function automatic logic [31:0] model_word();
        return {m_base, m_bw, m_size, 13'b0, m_mir, m_en, m_we};
    endfunction

    // Monitor: compares each queued expectation at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (it.is_read) begin
                if (reg_rdata !== it.exp_data) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual=%h expected=%h", it.tag, reg_rdata, it.exp_data);
                end
            end else begin
                if ({blk_sel, wr_permit, wr_reject} !== {it.exp_sel, it.exp_ok, it.exp_rej}) begin
                    n_fail++;
                    $display("FAIL %s: addr=%h sel/ok/rej actual=%b%b%b expected=%b%b%b",
                             it.tag, bus_addr, blk_sel, wr_permit, wr_reject,
                             it.exp_sel, it.exp_ok, it.exp_rej);
                end
            end
        end
    end

    task automatic do_reset(input logic bw, input logic mir);
        @(posedge clk); #1;
        rst = 1'b1; strap_bus_w = bw; strap_alias = mir;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        m_base = 12'hFF4; m_size = 3'd0; m_en = 0; m_we = 0; m_bw = bw; m_mir = mir;
    endtask

    task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a == REG_A) begin
            m_base = d[31:20]; m_size = d[18:16]; m_en = d[1]; m_we = d[0];
        end
    endtask

    task automatic reg_read(input logic [31:0] a, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.is_read = 1; it.exp_data = (a == REG_A) ? model_word() : 32'h0;
        it.exp_sel = 0; it.exp_ok = 0; it.exp_rej = 0; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic decode(input logic [31:0] a, input logic wr, input string tag);
        item_t it;
        longint unsigned span, start, aa;
        logic hit, mir;
        @(posedge clk); #1;
        bus_addr = a; bus_wr = wr;
        span  = 64'd1 << (20 + m_size);
        start = {32'h0, m_base, 20'h0} & ~(span - 64'd1);
        aa    = {32'h0, a};
        hit   = (aa >= start) && (aa < start + span);
        mir   = m_mir && (a >= 32'hFFF0_0000);
        it.is_read  = 0; it.exp_data = '0;
        it.exp_sel  = m_en && (hit || mir);
        it.exp_ok   = it.exp_sel && wr && m_we;
        it.exp_rej  = it.exp_sel && wr && !m_we;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1, 1'b1);
        reg_read(REG_A, "R1 reset word");                     // 0xFF480004
        decode(32'hFF40_0000, 1'b0, "R7 disabled after reset");
        decode(32'hFFF0_0000, 1'b1, "R7 disabled mirror");

        // All-ones write: read-only bits and zero field must hold
        reg_write(REG_A, 32'hFFFF_FFFF);
        reg_read(REG_A, "R4 all-ones write");
        // All-zeros write keeps strap bits high
        reg_write(REG_A, 32'h0000_0000);
        reg_read(REG_A, "R4 all-zeros write");
        decode(32'h0000_0000, 1'b0, "R7 base 0 disabled");

        // Base 0xFF4, 1 MB, enabled, writes blocked
        reg_write(REG_A, 32'hFF40_0002);
        reg_read(REG_A, "R3 R2 field layout");
        decode(32'hFF40_0000, 1'b0, "R6 start");
        decode(32'hFF4F_FFFF, 1'b0, "R6 last byte");
        decode(32'hFF50_0000, 1'b0, "R6 past end");
        decode(32'hFF3F_FFFF, 1'b0, "R6 before start");
        decode(32'hFF40_0010, 1'b1, "R10 reject write");
        decode(32'hFFF0_0000, 1'b0, "R8 mirror low");
        decode(32'hFFFF_FFFF, 1'b1, "R8 mirror top write R10");
        decode(32'hFFEF_FFFF, 1'b0, "R8 below mirror");

        // 8 MB, writes allowed: base 0xFF4 masks to 0xFF0
        reg_write(REG_A, 32'hFF43_0003);
        decode(32'hFF00_0000, 1'b1, "R6 R9 masked start write");
        decode(32'hFF7F_FFFF, 1'b0, "R6 masked last");
        decode(32'hFF80_0000, 1'b1, "R6 R9 masked past end");
        decode(32'hFF12_3456, 1'b0, "R9 read no permit");

        // Sweep of size codes with low base bits set
        for (int n = 0; n < 8; n++) begin
            longint unsigned sp, st;
            reg_write(REG_A, {12'h3A5, 1'b0, 3'(n), 13'h0, 3'b011});
            sp = 64'd1 << (20 + n);
            st = {32'h0, 12'h3A5, 20'h0} & ~(sp - 64'd1);
            decode(st[31:0],              1'b1, "R6 R9 sweep start");
            decode(32'(st + sp - 64'd1),  1'b0, "R6 sweep last");
            decode(32'(st + sp),          1'b1, "R6 sweep past end");
            decode(32'(st - 64'd1),       1'b0, "R6 sweep before start");
        end

        // Non-matching register address
        reg_read(32'hFEF8_005C, "R5 other address reads zero");
        reg_write(32'hFEF8_005C, 32'h1230_0000);
        reg_read(REG_A, "R5 other-address write ignored");

        // Strap change after reset ignored
        @(posedge clk); #1;
        strap_bus_w = 1'b0; strap_alias = 1'b0;
        reg_read(REG_A, "R4 strap change ignored");

        // Reset with mirror strap low, bus-width strap low
        do_reset(1'b0, 1'b0);
        reg_read(REG_A, "R1 reset with low straps");
        reg_write(REG_A, 32'h0000_0003);
        decode(32'hFFF0_0000, 1'b0, "R8 mirror off low");
        decode(32'hFFFF_FFFF, 1'b1, "R8 mirror off top");
        decode(32'h000F_FFFF, 1'b1, "R6 R9 base zero last");
        reg_write(REG_A, 32'hFFF0_0002);
        decode(32'hFFF8_0000, 1'b1, "R6 R10 base at top");

        @(posedge clk); #1;
        @(negedge clk); #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule